// File: doc/BRIEF.md
# Staged Table Access Engine

This block gives a processor indirect access to two internal configuration tables over a simple 32-bit register bus. The first table holds 32 scheme entries of 23 words each. The second holds 64 port entries of two words each. No table word has its own bus address. Software stages data in a shared window of 23 words that starts at byte offset 0x100. It then writes a single action word at offset 0x1FC. That word names the table, the entry, the direction and, for port entries, the sub-words to move.

After a valid command, the engine moves one word per clock between the window and the chosen entry. It holds the GO bit of the action word at 1 for the whole transfer and clears it when the last word has moved. A command that cannot be carried out is refused on the spot. It sets an error flag and changes no table contents. Three plain configuration words sit next to the window: a global configuration word at 0x000, whose bit 31 is the global enable, a scheme error event word at 0x01C and its enable word at 0x020.

Top module: `tbl_window_access`

## Requirements
- R1: After reset, every bus-visible word reads 0. This covers the configuration words, all window words and the action word, so GO (bit 31) and the error flag (bit 29) read 0.
- R2: The words at 0x000, 0x01C and 0x020 read back exactly the last value written to them.
- R3: Window word i (i from 0 to 22) is read and written at byte address 0x100+4*i. Any unmapped address reads 0, including 0x15C.
- R4: A scheme write copies all 23 window words into the scheme entry whose index is in bits 23:16 of the action word. A scheme write is an action write with bit 31=1, bit 30=0, bit 25=0 and bit 24=0. GO reads 1 for exactly 23 clocks after the action write and then reads 0, with the error flag at 0.
- R5: A scheme read is the same command with bit 30=1. It copies the 23 words of the entry into the window, and GO reads 1 for 23 clocks.
- R6: Entry word 16, the packet counter at window offset 0x140, is replaced on a scheme write only when bit 15 of the action word is 1. Otherwise the entry keeps its previous counter value.
- R7: A port command (bit 25=1) addresses the port entry in bits 7:0. Bit 15 selects the scheme-partition word, which pairs with the window word at 0x100. Bit 14 selects the classification-plan-partition word, which pairs with 0x104. Only the selected words move, in either direction. GO reads 1 for 2 clocks.
- R8: A GO command is refused in any of these cases: bit 24 is 1, a scheme index is 32 or more, a port index is 63 or more, or bits 15 and 14 are both 1 on a port command. When refused, the error flag reads 1, GO reads 0 from the next clock and no table entry changes. The next valid GO command clears the flag.
- R9: While GO reads 1, bus writes to the window and to the action word have no effect.
- R10: Reading the action word returns the last accepted action value, with bit 31 replaced by the busy state and bit 29 by the error flag. An action write with bit 31=0 starts nothing and leaves the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 9 | Byte address; bits 1:0 must be 0 for a hit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |

## Verification
The checker assumes that software does not change a command while it runs: the stored action word moves only on an accepted write. It also assumes that the bus issues no window or action writes that the engine is meant to act on while GO is 1. The stimulus follows the same discipline as driver software: stage the window, issue one command and poll GO until it falls. The one exception is a deliberate burst of writes to the window and to the action word during a transfer, and those must be dropped. Table entries are only read back after a full write has defined them.

// File: rtl/twa_pkg.sv
package twa_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Action word bit positions (software-visible layout)
  localparam int unsigned ACT_GO   = 31;
  localparam int unsigned ACT_RD   = 30;
  localparam int unsigned ACT_ERR  = 29;
  localparam int unsigned ACT_PORT = 25;
  localparam int unsigned ACT_PLAN = 24;
  localparam int unsigned ACT_B15  = 15;
  localparam int unsigned ACT_B14  = 14;

  // Refusal rule for a GO command
  function automatic logic act_bad(input logic plan, input logic port,
                                   input logic [7:0] sidx, input logic [7:0] pidx,
                                   input logic b15, input logic b14,
                                   input int unsigned nsch, input int unsigned nport_ok);
    if (plan) return 1'b1;
    if (port) return (32'(pidx) >= nport_ok) || (b15 && b14);
    return 32'(sidx) >= nsch;
  endfunction

  // Readback value of the action word
  function automatic word_t act_status(input word_t raw, input logic busy, input logic err);
    word_t s;
    s = raw;
    s[ACT_GO]  = busy;
    s[ACT_ERR] = err;
    return s;
  endfunction
endpackage

// File: rtl/twa_seq.sv
module twa_seq
  import twa_pkg::*;
#(
  parameter int unsigned NUM_SCHEMES = 32,
  parameter int unsigned NUM_PORTS   = 64,
  parameter int unsigned WIN_WORDS   = 23,
  parameter int unsigned STEP_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_acc,
  input  word_t             act_wdata,
  output logic              busy,
  output logic              err,
  output word_t             act_q,
  output logic [STEP_W-1:0] step
);
  localparam int unsigned PORT_OK = NUM_PORTS - 1;  // top port entry is reserved
  localparam logic [STEP_W-1:0] SCH_LAST = STEP_W'(WIN_WORDS - 1);
  localparam logic [STEP_W-1:0] PRT_LAST = STEP_W'(1);

  logic              busy_q, err_q;
  word_t             act_r;
  logic [STEP_W-1:0] step_q;
  logic              refuse;
  logic [STEP_W-1:0] last_step;

  assign refuse = act_bad(act_wdata[ACT_PLAN], act_wdata[ACT_PORT],
                          act_wdata[23:16], act_wdata[7:0],
                          act_wdata[ACT_B15], act_wdata[ACT_B14],
                          NUM_SCHEMES, PORT_OK);
  assign last_step = act_r[ACT_PORT] ? PRT_LAST : SCH_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      act_r  <= '0;
      step_q <= '0;
    end else if (act_acc) begin
      act_r  <= act_wdata;
      step_q <= '0;
      if (act_wdata[ACT_GO]) begin
        err_q  <= refuse;
        busy_q <= !refuse;
      end
    end else if (busy_q) begin
      if (step_q == last_step) busy_q <= 1'b0;
      else                     step_q <= step_q + 1'b1;
    end
  end

  assign busy  = busy_q;
  assign err   = err_q;
  assign act_q = act_r;
  assign step  = step_q;
endmodule

// File: rtl/twa_scheme_store.sv
module twa_scheme_store
  import twa_pkg::*;
#(
  parameter int unsigned NUM_SCHEMES = 32,
  parameter int unsigned WIN_WORDS   = 23,
  parameter int unsigned SCH_IW      = 5,
  parameter int unsigned STEP_W      = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SCH_IW-1:0] idx,
  input  logic [STEP_W-1:0] word,
  input  word_t             wdata,
  output word_t             rdata
);
  localparam int unsigned DEPTH = NUM_SCHEMES * WIN_WORDS;
  localparam int unsigned AW    = $clog2(DEPTH);

  word_t          mem [DEPTH];
  logic [AW-1:0]  addr;

  assign addr = AW'(idx) * AW'(WIN_WORDS) + AW'(word);

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/twa_port_store.sv
module twa_port_store
  import twa_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 64,
  parameter int unsigned PRT_IW    = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PRT_IW-1:0] idx,
  input  logic              word,
  input  word_t             wdata,
  output word_t             rdata
);
  word_t rd_word [2];

  for (genvar w = 0; w < 2; w++) begin : g_word
    word_t bank [NUM_PORTS];
    always_ff @(posedge clk) begin
      if (we && (word == 1'(w))) bank[idx] <= wdata;
    end
    assign rd_word[w] = bank[idx];
  end

  assign rdata = rd_word[word];
endmodule

// File: rtl/tbl_window_access.sv
module tbl_window_access
  import twa_pkg::*;
#(
  parameter int unsigned NUM_SCHEMES = 32,
  parameter int unsigned NUM_PORTS   = 64,
  parameter int unsigned WIN_WORDS   = 23,
  parameter int unsigned CNT_WORD    = 16,
  parameter int unsigned ADDR_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned STEP_W = $clog2(WIN_WORDS);
  localparam int unsigned SCH_IW = $clog2(NUM_SCHEMES);
  localparam int unsigned PRT_IW = $clog2(NUM_PORTS);
  localparam int unsigned WA_W   = ADDR_W - 2;
  localparam logic [WA_W-1:0] W_GCFG    = WA_W'(0);
  localparam logic [WA_W-1:0] W_SERR    = WA_W'(7);
  localparam logic [WA_W-1:0] W_SERR_EN = WA_W'(8);
  localparam logic [WA_W-1:0] W_WIN     = WA_W'(64);
  localparam logic [WA_W-1:0] W_WIN_END = WA_W'(64 + WIN_WORDS);
  localparam logic [WA_W-1:0] W_ACT     = WA_W'(127);
  localparam logic [STEP_W-1:0] CNT_STEP = STEP_W'(CNT_WORD);

  // Bus decode
  logic [WA_W-1:0]   waddr;
  logic              aligned, win_hit, act_acc, win_wr;
  logic [STEP_W-1:0] win_idx;

  assign waddr   = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign win_hit = aligned && (waddr >= W_WIN) && (waddr < W_WIN_END);
  assign win_idx = STEP_W'(waddr - W_WIN);

  // Sequencer
  logic              busy, err;
  word_t             act_q;
  logic [STEP_W-1:0] step;

  assign act_acc = bus_wr && aligned && (waddr == W_ACT) && !busy;
  assign win_wr  = bus_wr && win_hit && !busy;

  twa_seq #(
    .NUM_SCHEMES(NUM_SCHEMES), .NUM_PORTS(NUM_PORTS),
    .WIN_WORDS(WIN_WORDS), .STEP_W(STEP_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .act_acc(act_acc), .act_wdata(bus_wdata),
    .busy(busy), .err(err), .act_q(act_q), .step(step)
  );

  // Transfer events, named for the checker
  logic  is_rd, is_port, port_word_sel, cnt_skip;
  logic  sch_we, prt_we, win_load;
  word_t sch_rdata, prt_rdata, win_load_data, xfer_wdata;
  word_t win_q [WIN_WORDS];

  assign is_rd         = act_q[ACT_RD];
  assign is_port       = act_q[ACT_PORT];
  assign port_word_sel = (step == '0) ? act_q[ACT_B15] : act_q[ACT_B14];
  assign cnt_skip      = (step == CNT_STEP) && !act_q[ACT_B15];
  assign sch_we        = busy && !is_rd && !is_port && !cnt_skip;
  assign prt_we        = busy && !is_rd && is_port && port_word_sel;
  assign win_load      = busy && is_rd && (!is_port || port_word_sel);
  assign win_load_data = is_port ? prt_rdata : sch_rdata;
  assign xfer_wdata    = win_q[step];

  twa_scheme_store #(
    .NUM_SCHEMES(NUM_SCHEMES), .WIN_WORDS(WIN_WORDS),
    .SCH_IW(SCH_IW), .STEP_W(STEP_W)
  ) u_sch (
    .clk(clk), .we(sch_we), .idx(SCH_IW'(act_q[23:16])), .word(step),
    .wdata(xfer_wdata), .rdata(sch_rdata)
  );

  twa_port_store #(
    .NUM_PORTS(NUM_PORTS), .PRT_IW(PRT_IW)
  ) u_prt (
    .clk(clk), .we(prt_we), .idx(PRT_IW'(act_q[7:0])), .word(step[0]),
    .wdata(xfer_wdata), .rdata(prt_rdata)
  );

  // Window and plain configuration words
  word_t gcfg_q, serr_q, serr_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WIN_WORDS); i++) win_q[i] <= '0;
    end else if (win_load) begin
      win_q[step] <= win_load_data;
    end else if (win_wr) begin
      win_q[win_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcfg_q    <= '0;
      serr_q    <= '0;
      serr_en_q <= '0;
    end else if (bus_wr && aligned) begin
      if (waddr == W_GCFG)    gcfg_q    <= bus_wdata;
      if (waddr == W_SERR)    serr_q    <= bus_wdata;
      if (waddr == W_SERR_EN) serr_en_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (waddr == W_GCFG)         bus_rdata = gcfg_q;
      else if (waddr == W_SERR)    bus_rdata = serr_q;
      else if (waddr == W_SERR_EN) bus_rdata = serr_en_q;
      else if (waddr == W_ACT)     bus_rdata = act_status(act_q, busy, err);
      else if (win_hit)            bus_rdata = win_q[win_idx];
    end
  end
endmodule

// File: rtl/twa_checker.sv
module twa_checker
  import twa_pkg::*;
#(
  parameter int unsigned WIN_WORDS = 23,
  parameter int unsigned CNT_WORD  = 16,
  parameter int unsigned STEP_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              err,
  input word_t             act_q,
  input logic [STEP_W-1:0] step,
  input logic              sch_we,
  input logic              prt_we,
  input logic              bus_wr
);
  localparam logic [STEP_W:0]   SCH_LEN  = (STEP_W+1)'(WIN_WORDS);
  localparam logic [STEP_W:0]   PRT_LEN  = (STEP_W+1)'(2);
  localparam logic [STEP_W-1:0] CNT_STEP = STEP_W'(CNT_WORD);

  logic [STEP_W:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R4 R5 R7: transfer length matches the entry type
  a_r4_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == (act_q[ACT_PORT] ? PRT_LEN : SCH_LEN)));

  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  a_r8_no_plan_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !act_q[ACT_PLAN]);

  a_r8_no_dual_word_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && act_q[ACT_PORT]) |-> !(act_q[ACT_B15] && act_q[ACT_B14]));

  a_r9_action_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable(act_q));

  a_r6_counter_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (sch_we && step == CNT_STEP) |-> act_q[ACT_B15]);

  a_r7_port_word_select: assert property (@(posedge clk) disable iff (!rst_n)
    prt_we |-> ((step == '0) ? act_q[ACT_B15] : act_q[ACT_B14]));
endmodule

bind tbl_window_access twa_checker #(
  .WIN_WORDS(WIN_WORDS), .CNT_WORD(CNT_WORD), .STEP_W(STEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .act_q(act_q),
  .step(step), .sch_we(sch_we), .prt_we(prt_we), .bus_wr(bus_wr)
);

// File: tb/tbl_window_access_test.sv
module tbl_window_access_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSCH = 32;
  localparam int NPRT = 64;
  localparam int NWIN = 23;
  localparam int CNTW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbl_window_access uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference model
  logic [31:0] win_m [NWIN];
  logic [31:0] sch_m [NSCH][NWIN];
  logic [31:0] prt_m [NPRT][2];
  logic [31:0] act_m = '0;
  bit          err_m = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_win(input int i, input logic [31:0] d);
    wr(9'(256 + 4*i), d);
    win_m[i] = d;
  endtask

  function automatic logic [31:0] sch_cmd(input bit r, input int idx, input bit cnt);
    return 32'h8000_0000 | (32'(r) << 30) | (32'(idx) << 16) | (32'(cnt) << 15);
  endfunction

  function automatic logic [31:0] prt_cmd(input bit r, input int idx, input bit sp, input bit cpp);
    return 32'h8000_0000 | (32'(r) << 30) | 32'h0200_0000 |
           (32'(sp) << 15) | (32'(cpp) << 14) | 32'(idx);
  endfunction

  function automatic bit refused(input logic [31:0] c);
    if (c[24]) return 1;
    if (c[25]) return (int'(c[7:0]) >= NPRT - 1) || (c[15] && c[14]);
    return int'(c[23:16]) >= NSCH;
  endfunction

  function automatic int run_len(input logic [31:0] c);
    if (!c[31] || refused(c)) return 0;
    return c[25] ? 2 : NWIN;
  endfunction

  task automatic apply_model(input logic [31:0] c);
    act_m = c;
    if (!c[31]) return;
    err_m = refused(c);
    if (err_m) return;
    if (c[25]) begin
      for (int w = 0; w < 2; w++) begin
        if ((w == 0) ? c[15] : c[14]) begin
          if (c[30]) win_m[w] = prt_m[int'(c[7:0])][w];
          else       prt_m[int'(c[7:0])][w] = win_m[w];
        end
      end
    end else begin
      for (int w = 0; w < NWIN; w++) begin
        if (c[30])                  win_m[w] = sch_m[int'(c[23:16])][w];
        else if (w != CNTW || c[15]) sch_m[int'(c[23:16])][w] = win_m[w];
      end
    end
  endtask

  function automatic logic [31:0] status_m();
    logic [31:0] s;
    s = act_m;
    s[31] = 1'b0;
    s[29] = err_m;
    return s;
  endfunction

  // Issue a command and compare GO against the model on every clock
  task automatic go(input logic [31:0] c, input string tag);
    logic [31:0] d;
    int len;
    len = run_len(c);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'h1FC; bus_wdata = c;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int i = 0; i <= len; i++) begin
      rd(9'h1FC, d);
      check({tag, " GO per clock"}, {31'd0, d[31]}, {31'd0, (i < len)});
      if (i < len) @(negedge clk);
    end
    apply_model(c);
    rd(9'h1FC, d);
    check({tag, " action status"}, d, status_m());
  endtask

  task automatic chk_win(input string tag);
    logic [31:0] d;
    for (int w = 0; w < NWIN; w++) begin
      rd(9'(256 + 4*w), d);
      check(tag, d, win_m[w]);
    end
  endtask

  task automatic clear_win();
    for (int w = 0; w < NWIN; w++) wr_win(w, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int w = 0; w < NWIN; w++) win_m[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(9'h000, d); check("R1 gcfg reset", d, 32'h0);
    rd(9'h01C, d); check("R1 serr reset", d, 32'h0);
    rd(9'h020, d); check("R1 serr_en reset", d, 32'h0);
    rd(9'h1FC, d); check("R1 action reset", d, 32'h0);
    chk_win("R1 window reset");

    // R2: plain words
    wr(9'h000, 32'h8000_0502); rd(9'h000, d); check("R2 gcfg", d, 32'h8000_0502);
    wr(9'h01C, 32'hFFFF_FFFF); rd(9'h01C, d); check("R2 serr", d, 32'hFFFF_FFFF);
    wr(9'h020, 32'h1234_5678); rd(9'h020, d); check("R2 serr_en", d, 32'h1234_5678);

    // R3: window map
    for (int w = 0; w < NWIN; w++) wr_win(w, 32'hA500_0000 + 32'(w) * 32'h0101_0101);
    chk_win("R3 window words");
    wr(9'h15C, 32'hDEAD_BEEF); rd(9'h15C, d); check("R3 unmapped reads 0", d, 32'h0);

    // R4: scheme write with counter load
    go(sch_cmd(0, 5, 1), "R4 scheme write");
    // R6: second write without counter load
    for (int w = 0; w < NWIN; w++) wr_win(w, 32'h3C00_0000 ^ (32'(w) << 4));
    go(sch_cmd(0, 5, 0), "R6 scheme write no counter");
    clear_win();
    // R5: read back entry
    go(sch_cmd(1, 5, 0), "R5 scheme read");
    chk_win("R5 R6 scheme entry contents");
    // boundary index 31
    for (int w = 0; w < NWIN; w++) wr_win(w, 32'h0F0F_0000 + 32'(w));
    go(sch_cmd(0, 31, 1), "R4 scheme write idx 31");
    clear_win();
    go(sch_cmd(1, 31, 0), "R5 scheme read idx 31");
    chk_win("R5 scheme idx 31 contents");

    // R7: port words
    wr_win(0, 32'h8400_0000); wr_win(1, 32'h0000_00C3);
    go(prt_cmd(0, 10, 1, 0), "R7 port SP write");
    wr_win(0, 32'h1111_1111);
    go(prt_cmd(0, 10, 0, 1), "R7 port CPP write");
    wr_win(0, 32'h0); wr_win(1, 32'h0);
    go(prt_cmd(1, 10, 1, 0), "R7 port SP read");
    rd(9'h100, d); check("R7 SP into window", d, win_m[0]);
    rd(9'h104, d); check("R7 CPP window untouched", d, 32'h0);
    go(prt_cmd(1, 10, 0, 1), "R7 port CPP read");
    chk_win("R7 port entry 10");
    wr_win(0, 32'h0000_0001);
    go(prt_cmd(0, 62, 1, 0), "R7 port 62 write");
    wr_win(0, 32'h0);
    go(prt_cmd(1, 62, 1, 0), "R7 port 62 read");
    chk_win("R7 port entry 62");

    // R8: refusals
    wr_win(0, 32'hBAD0_0000); wr_win(1, 32'hBAD0_0001);
    go(prt_cmd(0, 10, 1, 1), "R8 both port words");
    go(prt_cmd(0, 63, 1, 0), "R8 port index 63");
    go(sch_cmd(0, 32, 1), "R8 scheme index 32");
    go(sch_cmd(0, 5, 1) | 32'h0100_0000, "R8 plan selector");
    go(32'h0000_0005, "R10 action without GO");
    rd(9'h1FC, d); check("R10 err kept without GO", {31'd0, d[29]}, 32'd1);
    go(prt_cmd(1, 10, 1, 0), "R8 valid clears err");
    go(prt_cmd(1, 10, 0, 1), "R8 port 10 read");
    rd(9'h100, d); check("R8 SP unchanged", d, 32'h8400_0000);
    rd(9'h104, d); check("R8 CPP unchanged", d, 32'h0000_00C3);
    clear_win();
    go(sch_cmd(1, 5, 0), "R8 scheme 5 read");
    chk_win("R8 scheme 5 unchanged");

    // R9: writes during a transfer are dropped
    for (int w = 0; w < NWIN; w++) wr_win(w, 32'h7700_0000 + 32'(w));
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'h1FC; bus_wdata = sch_cmd(0, 7, 1);
    @(negedge clk);
    bus_addr = 9'h10C; bus_wdata = 32'hFEED_0003;
    @(negedge clk);
    bus_addr = 9'h1FC; bus_wdata = sch_cmd(1, 2, 0);
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (30) @(negedge clk);
    apply_model(sch_cmd(0, 7, 1));
    rd(9'h10C, d); check("R9 window write dropped", d, win_m[3]);
    rd(9'h1FC, d); check("R9 action write dropped", d, status_m());
    clear_win();
    go(sch_cmd(1, 7, 0), "R9 scheme 7 read");
    chk_win("R9 scheme 7 contents");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule